// File: doc/BRIEF.md
# ECC-Protected Synchronous Dual-Port RAM

This block is a true dual-port memory of 64-bit words. Each stored word carries 8 check bits of an extended Hamming code. The two ports, A and B, each have their own clock, reset, enable, write enable, address and write data. Apart from the stored contents they share nothing. Every input is sampled on the rising edge of its port clock, so nothing happens between edges. On a write, the port encodes the data and stores the 72-bit codeword. On a read, the port decodes the codeword, repairs a single flipped bit and reports an uncorrectable double flip.

Each port has two build-time choices. The first is what its read output shows during a write cycle: the word previously held at that address, the word being written, or no change at all. The second is an extra output register, which adds one cycle of latency and keeps the data, the valid flag and the two error flags in step.

A port accepts one operation in every enabled cycle. There is no ready signal, so the port never applies back-pressure. The result comes with a one-cycle valid pulse, and the consumer has to take it in that cycle. A test-only flip mask per port is XORed into the codeword at write time, so that stored errors can be created on purpose. In normal use it is tied to zero.

Top module: `eccram_dp`

## Requirements
- R1: After an enabled read at address X, the port presents the decoded word at X with rvld high. Without the output register it appears in the cycle after the capturing edge.
- R2: While a port is not enabled, its rdata and flags keep their last values, and rvld is low in the following result cycle.
- R3: In old-word mode (RDW_OLD = 0), a write cycle presents the word stored at that address before the write, with rvld high.
- R4: In new-word mode (RDW_NEW = 1), a write cycle presents the word being written, with rvld high.
- R5: In hold mode (RDW_HOLD = 2), a write cycle leaves rdata unchanged and rvld low.
- R6: With the output register enabled, data, rvld, sec and ded all arrive exactly one cycle later than without it.
- R7: A stored codeword with exactly one inverted bit, at any of the 72 positions, reads back with the original data, sec=1 and ded=0.
- R8: A stored codeword with exactly two inverted bits reads back with ded=1 and sec=0. The data value is not defined in that case.
- R9: A clean stored codeword reads back with sec=0 and ded=0.
- R10: A word written through one port can be read through the other. Operations on different addresses through both ports in the same cycle do not disturb each other.
- R11: After reset, each port drives rdata=0, rvld=0, sec=0 and ded=0.
- R12: Bit i of a port's flip mask inverts bit i of the codeword stored by that port's write. Codeword bit 0 is the overall parity bit. Bits 1, 2, 4, 8, 16, 32 and 64 are position checks. The data occupies the remaining bits in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A asynchronous active-low reset |
| a_en | input | 1 | Port A operation enable |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | 64 | Port A write data |
| a_flip | input | 72 | Port A test-only codeword flip mask |
| a_rdata | output | 64 | Port A decoded read data |
| a_rvld | output | 1 | Port A result valid pulse |
| a_sec | output | 1 | Port A single error corrected |
| a_ded | output | 1 | Port A double error detected |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B asynchronous active-low reset |
| b_en | input | 1 | Port B operation enable |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | 64 | Port B write data |
| b_flip | input | 72 | Port B test-only codeword flip mask |
| b_rdata | output | 64 | Port B decoded read data |
| b_rvld | output | 1 | Port B result valid pulse |
| b_sec | output | 1 | Port B single error corrected |
| b_ded | output | 1 | Port B double error detected |

## Verification
The codec is exercised with clean words, with single flips at the overall parity bit, at a check bit, at the top data bit and at random positions, and with flip pairs. These cases separate a correct repair from a misplaced one, and detection of a double error from a false repair. Random mixes of reads and writes on both ports, checked against a word model, show whether a word written through one port is seen through the other. A second instance set to hold mode shows whether the three write-cycle output policies differ as intended. The pipelined port, when compared with the unpipelined one, shows whether the flags stay aligned with the data.

// File: rtl/eccram_pkg.sv
package eccram_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int CW_W   = DATA_W + CHK_W;
  localparam int SYN_W  = CHK_W - 1;

  typedef enum logic [1:0] {
    RDW_OLD  = 2'd0,
    RDW_NEW  = 2'd1,
    RDW_HOLD = 2'd2
  } rdw_e;

  function automatic logic is_check_pos(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  // Spread data bits over the non power-of-two positions, in ascending order.
  function automatic logic [CW_W-1:0] spread(input logic [DATA_W-1:0] d);
    logic [CW_W-1:0] c;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p < CW_W; p++) begin
      if (!is_check_pos(p)) begin
        c[p] = d[k];
        k++;
      end
    end
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] gather(input logic [CW_W-1:0] c);
    logic [DATA_W-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p < CW_W; p++) begin
      if (!is_check_pos(p)) begin
        d[k] = c[p];
        k++;
      end
    end
    return d;
  endfunction

  // XOR of the positions of all set bits above position 0.
  function automatic logic [SYN_W-1:0] position_xor(input logic [CW_W-1:0] c);
    logic [SYN_W-1:0] s;
    s = '0;
    for (int p = 1; p < CW_W; p++) begin
      if (c[p]) s = s ^ SYN_W'(p);
    end
    return s;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import eccram_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CW_W-1:0]   cw
);
  logic [CW_W-1:0]  body;
  logic [SYN_W-1:0] chk;

  always_comb begin
    body = spread(data);
    chk  = position_xor(body);
    for (int j = 0; j < SYN_W; j++) begin
      body[1 << j] = chk[j];
    end
    body[0] = ^body[CW_W-1:1];
    cw      = body;
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import eccram_pkg::*;
(
  input  logic [CW_W-1:0]   cw,
  output logic [DATA_W-1:0] data,
  output logic              sec,
  output logic              ded
);
  logic [SYN_W-1:0] syn;
  logic             par;
  logic [CW_W-1:0]  fixed;
  int               idx;

  always_comb begin
    syn   = position_xor(cw);
    par   = ^cw;
    idx   = int'(syn);
    fixed = cw;
    sec   = 1'b0;
    ded   = 1'b0;
    if (par) begin
      if (idx < CW_W) begin
        fixed[idx] = ~cw[idx];
        sec        = 1'b1;
      end else begin
        ded = 1'b1;
      end
    end else if (syn != '0) begin
      ded = 1'b1;
    end
    data = gather(fixed);
  end
endmodule

// File: rtl/eccram_port.sv
module eccram_port
  import eccram_pkg::*;
#(
  parameter int   ADDR_W  = 5,
  parameter rdw_e RDW     = RDW_OLD,
  parameter bit   OUT_REG = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CW_W-1:0]   flip,
  input  logic [CW_W-1:0]   peer_word,
  input  logic [ADDR_W-1:0] peer_addr,
  output logic [CW_W-1:0]   own_at_peer,
  output logic [DATA_W-1:0] rdata,
  output logic              rvld,
  output logic              sec,
  output logic              ded
);
  localparam int DEPTH = 1 << ADDR_W;

  // This port's share of the storage. A word is the XOR of both shares.
  logic [CW_W-1:0] bank [DEPTH];

  logic [CW_W-1:0]   enc_cw;
  logic [CW_W-1:0]   wr_cw;
  logic [CW_W-1:0]   stored_now;
  logic              load;
  logic [CW_W-1:0]   s1_cw;
  logic              s1_vld;
  logic [DATA_W-1:0] d1;
  logic              sec1;
  logic              ded1;

  secded_enc u_enc (.data(wdata), .cw(enc_cw));

  assign wr_cw       = enc_cw ^ flip;
  assign stored_now  = bank[addr] ^ peer_word;
  assign own_at_peer = bank[peer_addr];
  assign load        = en && (!we || RDW != RDW_HOLD);

  always_ff @(posedge clk) begin
    if (en && we) bank[addr] <= wr_cw ^ peer_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_cw  <= '0;
      s1_vld <= 1'b0;
    end else begin
      s1_vld <= load;
      if (load) s1_cw <= (we && RDW == RDW_NEW) ? wr_cw : stored_now;
    end
  end

  secded_dec u_dec (.cw(s1_cw), .data(d1), .sec(sec1), .ded(ded1));

  generate
    if (OUT_REG) begin : g_pipe
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rdata <= '0;
          rvld  <= 1'b0;
          sec   <= 1'b0;
          ded   <= 1'b0;
        end else begin
          rdata <= d1;
          rvld  <= s1_vld;
          sec   <= sec1;
          ded   <= ded1;
        end
      end
    end else begin : g_direct
      assign rdata = d1;
      assign rvld  = s1_vld;
      assign sec   = sec1;
      assign ded   = ded1;
    end
  endgenerate

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(sec && ded)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(s1_cw) && !s1_vld)); // R2

  generate
    if (RDW == RDW_NEW) begin : g_chk_new
      AST_NEW_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (en && we && flip == '0) |=> (d1 == $past(wdata) && !sec1 && !ded1)); // R4
    end
    if (RDW == RDW_HOLD) begin : g_chk_hold
      AST_HOLD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && we) |=> ($stable(d1) && !s1_vld)); // R5
    end
  endgenerate
endmodule

// File: rtl/eccram_dp.sv
module eccram_dp
  import eccram_pkg::*;
#(
  parameter int   ADDR_W    = 5,
  parameter rdw_e RDW_A     = RDW_OLD,
  parameter bit   OUT_REG_A = 1'b0,
  parameter rdw_e RDW_B     = RDW_NEW,
  parameter bit   OUT_REG_B = 1'b1
) (
  input  logic              clk_a,
  input  logic              rst_a_n,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [63:0]       a_wdata,
  input  logic [71:0]       a_flip,
  output logic [63:0]       a_rdata,
  output logic              a_rvld,
  output logic              a_sec,
  output logic              a_ded,
  input  logic              clk_b,
  input  logic              rst_b_n,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [63:0]       b_wdata,
  input  logic [71:0]       b_flip,
  output logic [63:0]       b_rdata,
  output logic              b_rvld,
  output logic              b_sec,
  output logic              b_ded
);
  logic [CW_W-1:0] share_a_at_b;
  logic [CW_W-1:0] share_b_at_a;

  eccram_port #(.ADDR_W(ADDR_W), .RDW(RDW_A), .OUT_REG(OUT_REG_A)) u_port_a (
    .clk(clk_a), .rst_n(rst_a_n), .en(a_en), .we(a_we), .addr(a_addr),
    .wdata(a_wdata), .flip(a_flip),
    .peer_word(share_b_at_a), .peer_addr(b_addr), .own_at_peer(share_a_at_b),
    .rdata(a_rdata), .rvld(a_rvld), .sec(a_sec), .ded(a_ded)
  );

  eccram_port #(.ADDR_W(ADDR_W), .RDW(RDW_B), .OUT_REG(OUT_REG_B)) u_port_b (
    .clk(clk_b), .rst_n(rst_b_n), .en(b_en), .we(b_we), .addr(b_addr),
    .wdata(b_wdata), .flip(b_flip),
    .peer_word(share_a_at_b), .peer_addr(a_addr), .own_at_peer(share_b_at_a),
    .rdata(b_rdata), .rvld(b_rvld), .sec(b_sec), .ded(b_ded)
  );
endmodule

// File: tb/eccram_dp_bench.sv
module eccram_dp_bench;
  import eccram_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        a_en = 0, a_we = 0;
  logic [4:0]  a_addr = '0;
  logic [63:0] a_wdata = '0;
  logic [71:0] a_flip = '0;
  logic [63:0] a_rdata;
  logic        a_rvld, a_sec, a_ded;
  logic        b_en = 0, b_we = 0;
  logic [4:0]  b_addr = '0;
  logic [63:0] b_wdata = '0;
  logic [71:0] b_flip = '0;
  logic [63:0] b_rdata;
  logic        b_rvld, b_sec, b_ded;

  logic        h_en = 0, h_we = 0;
  logic [4:0]  h_addr = '0;
  logic [63:0] h_wdata = '0;
  logic [63:0] h_rdata, hb_rdata;
  logic        h_rvld, h_sec, h_ded, hb_rvld, hb_sec, hb_ded;

  eccram_dp #(.ADDR_W(5), .RDW_A(RDW_OLD), .OUT_REG_A(1'b0),
              .RDW_B(RDW_NEW), .OUT_REG_B(1'b1)) u_eccram_dp (
    .clk_a(clk), .rst_a_n(rst_n), .a_en(a_en), .a_we(a_we), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_flip(a_flip), .a_rdata(a_rdata), .a_rvld(a_rvld),
    .a_sec(a_sec), .a_ded(a_ded),
    .clk_b(clk), .rst_b_n(rst_n), .b_en(b_en), .b_we(b_we), .b_addr(b_addr),
    .b_wdata(b_wdata), .b_flip(b_flip), .b_rdata(b_rdata), .b_rvld(b_rvld),
    .b_sec(b_sec), .b_ded(b_ded)
  );

  eccram_dp #(.ADDR_W(5), .RDW_A(RDW_HOLD), .OUT_REG_A(1'b0),
              .RDW_B(RDW_OLD), .OUT_REG_B(1'b1)) u_eccram_dp_hold (
    .clk_a(clk), .rst_a_n(rst_n), .a_en(h_en), .a_we(h_we), .a_addr(h_addr),
    .a_wdata(h_wdata), .a_flip(72'd0), .a_rdata(h_rdata), .a_rvld(h_rvld),
    .a_sec(h_sec), .a_ded(h_ded),
    .clk_b(clk), .rst_b_n(rst_n), .b_en(1'b0), .b_we(1'b0), .b_addr(5'd0),
    .b_wdata(64'd0), .b_flip(72'd0), .b_rdata(hb_rdata), .b_rvld(hb_rvld),
    .b_sec(hb_sec), .b_ded(hb_ded)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [63:0] ref_mem [32];
  int          ref_err [32];

  task automatic chk(input string req, input logic vld, input logic [63:0] got,
                     input logic s, input logic d, input logic [63:0] exp, input int nerr);
    bit ok;
    checks++;
    ok = vld;
    if (nerr >= 2)      ok = ok && d && !s;
    else if (nerr == 1) ok = ok && got == exp && s && !d;
    else                ok = ok && got == exp && !s && !d;
    if (!ok) begin
      failures++;
      $display("FAIL %s: vld=%0b data=%h sec=%0b ded=%0b expected vld=1 data=%h errors=%0d",
               req, vld, got, s, d, exp, nerr);
    end
  endtask

  task automatic chk_bit(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got=%0b expected=%0b", req, got, exp);
    end
  endtask

  // Port A: OLD mode, no output register; result one cycle after the edge.
  task automatic op_a(input logic we, input logic [4:0] ad, input logic [63:0] d,
                      input logic [71:0] f, input bit check, input string req);
    logic [63:0] e_d;
    int e_n;
    e_d = ref_mem[ad];
    e_n = ref_err[ad];
    @(negedge clk);
    a_en = 1; a_we = we; a_addr = ad; a_wdata = d; a_flip = f;
    @(posedge clk);
    @(negedge clk);
    a_en = 0; a_flip = '0;
    if (check) chk(req, a_rvld, a_rdata, a_sec, a_ded, e_d, e_n);
    if (we) begin
      ref_mem[ad] = d;
      ref_err[ad] = $countones(f);
    end
  endtask

  // Port B: NEW mode with output register; result two cycles after the edge.
  task automatic op_b(input logic we, input logic [4:0] ad, input logic [63:0] d,
                      input logic [71:0] f, input string req);
    logic [63:0] e_d;
    int e_n;
    e_d = we ? d : ref_mem[ad];
    e_n = we ? $countones(f) : ref_err[ad];
    @(negedge clk);
    b_en = 1; b_we = we; b_addr = ad; b_wdata = d; b_flip = f;
    @(posedge clk);
    @(negedge clk);
    b_en = 0; b_flip = '0;
    chk_bit({req, " R6 early"}, b_rvld, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chk(req, b_rvld, b_rdata, b_sec, b_ded, e_d, e_n);
    if (we) begin
      ref_mem[ad] = d;
      ref_err[ad] = $countones(f);
    end
  endtask

  task automatic op_h(input logic we, input logic [4:0] ad, input logic [63:0] d);
    @(negedge clk);
    h_en = 1; h_we = we; h_addr = ad; h_wdata = d;
    @(posedge clk);
    @(negedge clk);
    h_en = 0;
  endtask

  function automatic logic [71:0] one_hot(input int p);
    return 72'd1 << p;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] snap;
    void'($urandom(32'd20240917));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk_bit("R11 a_rvld", a_rvld, 1'b0);
    chk_bit("R11 a_rdata", a_rdata == '0, 1'b1);
    chk_bit("R11 b_rvld", b_rvld, 1'b0);
    chk_bit("R11 flags", a_sec | a_ded | b_sec | b_ded, 1'b0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 32; i++) op_a(1'b1, 5'(i), {$urandom, $urandom}, '0, 1'b0, "init");

    // R1, R9: clean read on port A
    op_a(1'b0, 5'd4, '0, '0, 1'b1, "R1 R9 read A");
    snap = a_rdata;
    // R2: idle keeps data, no valid
    repeat (3) @(negedge clk);
    chk_bit("R2 idle rvld", a_rvld, 1'b0);
    chk_bit("R2 idle rdata", a_rdata == snap, 1'b1);

    // R3: OLD mode shows previous word
    op_a(1'b1, 5'd4, 64'hDEAD_BEEF_0123_4567, '0, 1'b1, "R3 old word");
    // R4, R6: NEW mode on pipelined port B
    op_b(1'b1, 5'd5, 64'h0F0F_1234_5678_9ABC, '0, "R4 R6 new word");
    // R10: cross-port visibility
    op_b(1'b0, 5'd4, '0, '0, "R10 A->B");
    op_a(1'b0, 5'd5, '0, '0, 1'b1, "R10 B->A");

    // R7, R12: single flips at parity bit, check bit, top data bit
    op_a(1'b1, 5'd7, 64'h1111_2222_3333_4444, one_hot(0), 1'b0, "");
    op_b(1'b0, 5'd7, '0, '0, "R7 R12 flip bit0");
    op_a(1'b1, 5'd8, 64'hAAAA_5555_AAAA_5555, one_hot(1), 1'b0, "");
    op_a(1'b0, 5'd8, '0, '0, 1'b1, "R7 R12 flip check bit1");
    op_b(1'b1, 5'd9, 64'h8000_0000_0000_0001, one_hot(71), "R7 R12 flip bit71 new");
    op_a(1'b0, 5'd9, '0, '0, 1'b1, "R7 flip bit71 read");
    // R8: double flips
    op_a(1'b1, 5'd10, 64'h0123_4567_89AB_CDEF, one_hot(0) | one_hot(5), 1'b0, "");
    op_a(1'b0, 5'd10, '0, '0, 1'b1, "R8 double incl parity");
    op_b(1'b1, 5'd11, 64'hFEDC_BA98_7654_3210, one_hot(3) | one_hot(40), "R8 double new");
    // R9: overwrite restores a clean word
    op_a(1'b1, 5'd10, 64'h5A5A_5A5A_5A5A_5A5A, '0, 1'b1, "R8 R3 old double");
    op_a(1'b0, 5'd10, '0, '0, 1'b1, "R9 clean again");

    // R10: concurrent ops on distinct addresses
    @(negedge clk);
    a_en = 1; a_we = 1; a_addr = 5'd12; a_wdata = 64'hC0FF_EE00_C0FF_EE00;
    b_en = 1; b_we = 0; b_addr = 5'd13;
    @(posedge clk);
    @(negedge clk);
    a_en = 0; b_en = 0;
    chk("R10 R3 concurrent A", a_rvld, a_rdata, a_sec, a_ded, ref_mem[12], ref_err[12]);
    @(posedge clk);
    @(negedge clk);
    chk("R10 concurrent B", b_rvld, b_rdata, b_sec, b_ded, ref_mem[13], ref_err[13]);
    ref_mem[12] = 64'hC0FF_EE00_C0FF_EE00;
    ref_err[12] = 0;
    op_b(1'b0, 5'd12, '0, '0, "R10 concurrent write seen");

    // R5: hold mode instance
    op_h(1'b1, 5'd3, 64'h1234_0000_0000_4321);
    op_h(1'b0, 5'd3, '0);
    chk("R5 hold read", h_rvld, h_rdata, h_sec, h_ded, 64'h1234_0000_0000_4321, 0);
    op_h(1'b1, 5'd3, 64'h9999_8888_7777_6666);
    chk_bit("R5 hold write rvld", h_rvld, 1'b0);
    chk_bit("R5 hold write rdata", h_rdata == 64'h1234_0000_0000_4321, 1'b1);
    op_h(1'b0, 5'd3, '0);
    chk("R5 hold readback", h_rvld, h_rdata, h_sec, h_ded, 64'h9999_8888_7777_6666, 0);

    // Random mix, R1 R3 R4 R7 R8 R9 R10
    for (int n = 0; n < 400; n++) begin
      int sel, p1, p2;
      logic we;
      logic [4:0] ad;
      logic [71:0] f;
      sel = $urandom % 8;
      we  = ($urandom % 2) == 1;
      ad  = 5'($urandom % 32);
      p1  = $urandom % 72;
      p2  = (p1 + 1 + ($urandom % 71)) % 72;
      f   = '0;
      if (we && sel < 2) f = one_hot(p1);
      else if (we && sel == 2) f = one_hot(p1) | one_hot(p2);
      if ($urandom % 2) op_a(we, ad, {$urandom, $urandom}, f, 1'b1, "R1 R3 R7 R8 random A");
      else              op_b(we, ad, {$urandom, $urandom}, f, "R4 R7 R8 R10 random B");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule